// File: doc/BRIEF.md
# Reset Sequencer with Power and Brown-out Status

This block produces the internal reset of a small microcontroller core. Its inputs are a power-on pulse, a digital brown-out comparator output, an active-low external reset pin and three configuration fields: brown-out enable, power-up timer enable and oscillator mode. A slow reference clock times everything. Oscillator start-up is counted in oscillator ticks, which arrive as a one-cycle strobe on the reference clock.

After power-on, the block runs an optional power-up timer and then, for crystal oscillator modes, an oscillator start-up count. Only then can the core leave reset. A supply dip trips the brown-out logic only when it lasts longer than a filter window. A tripped brown-out holds reset for as long as the supply stays low. When the supply recovers, the power-up timer runs again. A new trip while that timer runs restarts the timer from zero once the supply recovers. The time-outs count from the power-on event, not from the pin. If the pin is held low past the time-outs, releasing it lets the core start after only the pin synchroniser delay.

A small status register keeps power-on and brown-out history as flags that software can set. Software sets each flag and later reads it back to learn which kind of reset occurred.

Top module: `rstgen_top`

## Requirements
- R1: With the power-up timer disabled (`cfg_pwrt_n_i`=1) and oscillator mode 0 (external clock), `rst_int_o` falls 2 reference-clock edges after `por_i` falls, provided the pin is high. This delay comes from the pin synchroniser only.
- R2: With `cfg_pwrt_n_i`=0, `rst_int_o` stays high after `por_i` falls for PWRT_CYC edges of power-up timer. Any oscillator start-up count follows the timer.
- R3: Oscillator modes 2 and 3 (crystal) add an OST_CYC-tick start-up count after power-on, counting only edges where `osc_tick_i` is 1. Modes 0 and 1 add no such count.
- R4: With `cfg_bod_en_i`=1, `bod_low_i` high on FILT_CYC or fewer consecutive edges causes no reset. High on FILT_CYC+1 consecutive edges asserts `rst_int_o`.
- R5: A tripped brown-out holds `rst_int_o` high while `bod_low_i` stays high. After `bod_low_i` falls, reset ends PWRT_CYC+2 edges later with the timer enabled, or 2 edges later with it disabled. No oscillator start-up count is added.
- R6: A trip during the power-up timer discards the partial count. After recovery, reset again lasts the full PWRT_CYC+2 edges.
- R7: With `cfg_bod_en_i`=0, `bod_low_i` has no effect on `rst_int_o` or on the status flags.
- R8: The pin goes through a two-flop synchroniser. A low pin holds `rst_int_o` high but does not restart or delay the time-outs. Releasing the pin after the time-outs have expired ends reset 2 edges later.
- R9: `sw_rdata_o` bit 1 is the power-on flag and bit 0 is the brown-out flag. Bits 7..2 read as 0.
- R10: `por_i` clears the power-on flag. Pin resets and brown-out resets leave it unchanged. A write with `sw_wr_i` stores `sw_wdata_i` bit 1, visible after the next edge.
- R11: A brown-out trip clears the brown-out flag, and a trip wins over a simultaneous write. A pin reset leaves the flag unchanged. Otherwise a write stores `sw_wdata_i` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Slow reference clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bod_low_i | input | 1 | Comparator output: supply below brown-out threshold |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| cfg_bod_en_i | input | 1 | Brown-out detection enable |
| cfg_pwrt_n_i | input | 1 | Power-up timer enable, active low |
| cfg_osc_mode_i | input | 2 | 0 external clock, 1 internal oscillator, 2/3 crystal |
| osc_tick_i | input | 1 | One strobe per oscillator cycle |
| sw_wr_i | input | 1 | Status register write strobe |
| sw_wdata_i | input | 8 | Status register write data |
| sw_rdata_o | output | 8 | Status register read data |
| rst_int_o | output | 1 | Internal core reset, active high |

## Verification
The bench targets the filter edge: dips of exactly FILT_CYC and FILT_CYC+1 cycles. A design that is off by one there either resets on a permitted glitch or lets a real brown-out through. The bench also re-trips the brown-out partway through the power-up timer. A design that resumes the partial count releases reset too early. A pin held low through the whole power-on sequence and then released must end reset after the synchroniser delay only. A design that restarts the timers from the pin stretches reset by the full time-out. Finally, a write that coincides with a brown-out trip, and pin resets between flag writes, catch flags cleared by the wrong reset or overwritten by software during a trip.

// File: rtl/rstgen_pkg.sv
`timescale 1ns/1ps
package rstgen_pkg;

   typedef enum logic [1:0] {
      SEQ_PWRT  = 2'd0,
      SEQ_OST   = 2'd1,
      SEQ_BROWN = 2'd2,
      SEQ_RUN   = 2'd3
   } seq_state_e;

   typedef enum logic [1:0] {
      OSC_EXT = 2'd0,
      OSC_INT = 2'd1,
      OSC_XLP = 2'd2,
      OSC_XHS = 2'd3
   } osc_mode_e;

   // crystal modes need a start-up count, clock input and internal RC do not
   function automatic logic osc_needs_ost(input logic [1:0] mode);
      return (mode == OSC_XLP) || (mode == OSC_XHS);
   endfunction

   localparam int FLAG_BOD = 0;
   localparam int FLAG_POR = 1;

endpackage

// File: rtl/rstgen_sync.sv
`timescale 1ns/1ps
module rstgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rstgen_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= '0;
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rstgen_bod_filt.sv
`timescale 1ns/1ps
module rstgen_bod_filt #(
   parameter int FILT_CYC = 16
) (
   input  logic clk,
   input  logic arst,
   input  logic en,
   input  logic low,
   output logic trip
);
   localparam int            CW       = $clog2(FILT_CYC + 1);
   localparam logic [CW-1:0] FILT_LIM = CW'(FILT_CYC);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         run_cnt <= '0;
         trip    <= 1'b0;
      end else if (!en || !low) begin
         run_cnt <= '0;
         trip    <= 1'b0;
      end else begin
         trip <= (run_cnt == FILT_LIM);
         if (run_cnt != FILT_LIM) run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rstgen_seq.sv
`timescale 1ns/1ps
module rstgen_seq
   import rstgen_pkg::*;
#(
   parameter int PWRT_CYC = 72000,
   parameter int OST_CYC  = 1024
) (
   input  logic       clk,
   input  logic       arst,
   input  logic       trip,
   input  logic       pwrt_n,
   input  logic [1:0] osc_mode,
   input  logic       osc_tick,
   output logic       busy
);
   localparam int            CMAX      = (PWRT_CYC > OST_CYC) ? PWRT_CYC : OST_CYC;
   localparam int            CW        = $clog2(CMAX + 1);
   localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
   localparam logic [CW-1:0] OST_LAST  = CW'(OST_CYC - 1);

   seq_state_e    state;
   logic [CW-1:0] cnt;
   logic          por_path;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         state    <= SEQ_PWRT;
         cnt      <= '0;
         por_path <= 1'b1;
      end else if (trip) begin
         state    <= SEQ_BROWN;
         cnt      <= '0;
         por_path <= 1'b0;
      end else begin
         unique case (state)
            SEQ_PWRT: begin
               if (pwrt_n || cnt == PWRT_LAST) begin
                  cnt   <= '0;
                  state <= (por_path && osc_needs_ost(osc_mode)) ? SEQ_OST : SEQ_RUN;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            SEQ_OST: begin
               if (osc_tick) begin
                  if (cnt == OST_LAST) begin
                     cnt   <= '0;
                     state <= SEQ_RUN;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            SEQ_BROWN: begin
               cnt   <= '0;
               state <= pwrt_n ? SEQ_RUN : SEQ_PWRT;
            end
            default: begin
               state <= SEQ_RUN;
            end
         endcase
      end
   end

   assign busy = (state != SEQ_RUN);
endmodule

// File: rtl/rstgen_status.sv
`timescale 1ns/1ps
module rstgen_status
   import rstgen_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             trip,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata
);
   logic flag_por;
   logic flag_bod;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         flag_por <= 1'b0;
         flag_bod <= 1'b0;
      end else begin
         if (wr) flag_por <= wdata[FLAG_POR];
         if (trip)    flag_bod <= 1'b0;
         else if (wr) flag_bod <= wdata[FLAG_BOD];
      end
   end

   assign rdata[FLAG_BOD] = flag_bod;
   assign rdata[FLAG_POR] = flag_por;

   generate
      if (REG_W > 2) begin : g_upper
         logic unused_wdata_hi;
         assign unused_wdata_hi   = ^wdata[REG_W-1:2];
         assign rdata[REG_W-1:2] = '0;
      end
   endgenerate
endmodule

// File: rtl/rstgen_top.sv
`timescale 1ns/1ps
module rstgen_top #(
   parameter int FILT_CYC    = 16,
   parameter int PWRT_CYC    = 72000,
   parameter int OST_CYC     = 1024,
   parameter int SYNC_STAGES = 2,
   parameter int REG_W       = 8
) (
   input  logic             clk_ref_i,
   input  logic             por_i,
   input  logic             bod_low_i,
   input  logic             ext_rst_n_i,
   input  logic             cfg_bod_en_i,
   input  logic             cfg_pwrt_n_i,
   input  logic [1:0]       cfg_osc_mode_i,
   input  logic             osc_tick_i,
   input  logic             sw_wr_i,
   input  logic [REG_W-1:0] sw_wdata_i,
   output logic [REG_W-1:0] sw_rdata_o,
   output logic             rst_int_o
);
   generate
      if (FILT_CYC < 1) begin : g_bad_filt
         $error("rstgen_top: FILT_CYC must be at least 1");
      end
      if (PWRT_CYC < 1) begin : g_bad_pwrt
         $error("rstgen_top: PWRT_CYC must be at least 1");
      end
      if (OST_CYC < 1) begin : g_bad_ost
         $error("rstgen_top: OST_CYC must be at least 1");
      end
      if (REG_W < 2) begin : g_bad_regw
         $error("rstgen_top: REG_W must hold both flags");
      end
   endgenerate

   logic w_pin_ok;
   logic w_bod_trip;
   logic w_seq_busy;

   rstgen_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk  (clk_ref_i),
      .arst (por_i),
      .d    (ext_rst_n_i),
      .q    (w_pin_ok)
   );

   rstgen_bod_filt #(.FILT_CYC(FILT_CYC)) u_bod_filt (
      .clk  (clk_ref_i),
      .arst (por_i),
      .en   (cfg_bod_en_i),
      .low  (bod_low_i),
      .trip (w_bod_trip)
   );

   rstgen_seq #(.PWRT_CYC(PWRT_CYC), .OST_CYC(OST_CYC)) u_seq (
      .clk      (clk_ref_i),
      .arst     (por_i),
      .trip     (w_bod_trip),
      .pwrt_n   (cfg_pwrt_n_i),
      .osc_mode (cfg_osc_mode_i),
      .osc_tick (osc_tick_i),
      .busy     (w_seq_busy)
   );

   rstgen_status #(.REG_W(REG_W)) u_status (
      .clk   (clk_ref_i),
      .arst  (por_i),
      .trip  (w_bod_trip),
      .wr    (sw_wr_i),
      .wdata (sw_wdata_i),
      .rdata (sw_rdata_o)
   );

   assign rst_int_o = !w_pin_ok || w_seq_busy || w_bod_trip;
endmodule

// File: rtl/rstgen_chk.sv
`timescale 1ns/1ps
module rstgen_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             por,
   input logic             bod_low,
   input logic             bod_en,
   input logic             pin_n,
   input logic             sw_wr,
   input logic [REG_W-1:0] rdata,
   input logic             rst_int,
   input logic             trip
);
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (por)
      rdata[REG_W-1:2] == '0);  // R9

   AST_TRIP_HOLDS_RESET: assert property (@(posedge clk) disable iff (por)
      trip |-> rst_int);  // R5

   AST_TRIP_NEEDS_LOW: assert property (@(posedge clk) disable iff (por)
      trip |-> $past(bod_low));  // R4

   AST_DISABLED_NO_TRIP: assert property (@(posedge clk) disable iff (por)
      !bod_en |=> !trip);  // R7

   AST_PIN_HOLDS_RESET: assert property (@(posedge clk) disable iff (por)
      (!pin_n ##1 !pin_n) |=> rst_int);  // R8

   AST_POR_FLAG_STABLE: assert property (@(posedge clk) disable iff (por)
      !sw_wr |=> $stable(rdata[1]));  // R10

   AST_TRIP_CLEARS_BOD: assert property (@(posedge clk) disable iff (por)
      trip |=> !rdata[0]);  // R11
endmodule

bind rstgen_top rstgen_chk #(.REG_W(REG_W)) u_chk (
   .clk     (clk_ref_i),
   .por     (por_i),
   .bod_low (bod_low_i),
   .bod_en  (cfg_bod_en_i),
   .pin_n   (ext_rst_n_i),
   .sw_wr   (sw_wr_i),
   .rdata   (sw_rdata_o),
   .rst_int (rst_int_o),
   .trip    (w_bod_trip)
);

// File: tb/sim_rstgen_top.sv
`timescale 1ns/1ps
module sim_rstgen_top;
   localparam int FILT = 3;
   localparam int PWRT = 10;
   localparam int OST  = 6;

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       bod_low = 1'b0;
   logic       pin_n = 1'b1;
   logic       bod_en = 1'b1;
   logic       pwrt_n = 1'b1;
   logic [1:0] mode = 2'd0;
   logic       tick = 1'b1;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       rst_int;

   always #2.5 clk = ~clk;

   rstgen_top #(.FILT_CYC(FILT), .PWRT_CYC(PWRT), .OST_CYC(OST)) u0 (
      .clk_ref_i(clk), .por_i(por), .bod_low_i(bod_low), .ext_rst_n_i(pin_n),
      .cfg_bod_en_i(bod_en), .cfg_pwrt_n_i(pwrt_n), .cfg_osc_mode_i(mode),
      .osc_tick_i(tick), .sw_wr_i(wr), .sw_wdata_i(wdata),
      .sw_rdata_o(rdata), .rst_int_o(rst_int));

   int    n_chk = 0;
   int    n_err = 0;
   bit    mchk = 0;
   bit    saw_rst = 0;
   string cur_req = "R1";

   task automatic chk(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural expectation built from the requirements
   bit m_s1, m_s2, m_trip, m_porp, m_porf, m_bodf;
   int m_fc, m_st, m_cnt;
   bit t_trip;
   int t_fc;

   always @(posedge clk) begin
      if (por) begin
         m_s1 = 0; m_s2 = 0; m_trip = 0; m_fc = 0; m_st = 0; m_cnt = 0;
         m_porp = 1; m_porf = 0; m_bodf = 0;
      end else begin
         t_trip = bod_en && bod_low && (m_fc == FILT);
         t_fc   = (bod_en && bod_low) ? ((m_fc == FILT) ? FILT : m_fc + 1) : 0;
         if (m_trip) begin
            m_st = 2; m_cnt = 0; m_porp = 0;
         end else begin
            case (m_st)
               0: if (pwrt_n || m_cnt == PWRT - 1) begin
                     m_cnt = 0; m_st = (m_porp && mode[1]) ? 1 : 3;
                  end else m_cnt++;
               1: if (tick) begin
                     if (m_cnt == OST - 1) begin m_cnt = 0; m_st = 3; end
                     else m_cnt++;
                  end
               2: begin m_cnt = 0; m_st = pwrt_n ? 3 : 0; end
               default: ;
            endcase
         end
         if (m_trip) m_bodf = 0; else if (wr) m_bodf = wdata[0];
         if (wr) m_porf = wdata[1];
         m_s2 = m_s1; m_s1 = pin_n; m_trip = t_trip; m_fc = t_fc;
      end
   end

   function automatic bit m_rst();
      return !m_s2 || (m_st != 3) || m_trip;
   endfunction

   always @(negedge clk) begin
      if (rst_int) saw_rst = 1;
      if (mchk && !por) begin
         chk(cur_req, int'(rst_int), int'(m_rst()), "rst_int per cycle");
         chk(cur_req, int'(rdata), int'({m_porf, m_bodf}), "status per cycle");
      end
   end

   function automatic int exp_release(input bit pn, input logic [1:0] md);
      int n;
      n = (pn ? 1 : PWRT) + (md[1] ? OST : 0);
      return (n < 2) ? 2 : n;
   endfunction

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic wait_low(output int n);
      n = 0;
      while (rst_int && n < 5000) begin step(); n++; end
   endtask

   task automatic do_por(input bit pn, input logic [1:0] md);
      step(); pwrt_n = pn; mode = md; por = 1;
      step(); step(); por = 0;
   endtask

   task automatic dip(input int len);
      step(); bod_low = 1;
      repeat (len) step();
      bod_low = 0;
   endtask

   task automatic write_reg(input logic [7:0] d);
      wr = 1; wdata = d; step(); wr = 0;
   endtask

   initial begin
      #1000000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int n;
      void'($urandom(32'd1234));
      repeat (3) step();
      // R1: external clock, no timer
      cur_req = "R1";
      do_por(1, 2'd0); mchk = 1;
      chk("R1", int'(rdata), 0, "status after power-on");
      wait_low(n); chk("R1", n, exp_release(1, 2'd0), "release edges");
      // R2: timer enabled, external clock
      cur_req = "R2";
      do_por(0, 2'd0); wait_low(n); chk("R2", n, exp_release(0, 2'd0), "release edges");
      // R3: crystal adds start-up, internal oscillator does not
      cur_req = "R3";
      do_por(0, 2'd3); wait_low(n); chk("R3", n, PWRT + OST, "crystal release edges");
      do_por(1, 2'd2); wait_low(n); chk("R3", n, 1 + OST, "crystal no-timer edges");
      do_por(0, 2'd1); wait_low(n); chk("R3", n, PWRT, "internal osc edges");
      // R9 / R10 / R11: status flags
      cur_req = "R9";
      write_reg(8'hFF); chk("R9", int'(rdata), 3, "write all ones");
      cur_req = "R10";
      step(); pin_n = 0; repeat (3) step(); pin_n = 1; wait_low(n);
      chk("R10", int'(rdata), 3, "pin reset keeps flags");
      chk("R8", n, 2, "pin pulse in run ends after sync only");
      // R4: filter boundary, timer disabled path
      cur_req = "R4";
      do_por(1, 2'd0); wait_low(n); write_reg(8'h03);
      saw_rst = 0; dip(FILT); repeat (4) step();
      chk("R4", int'(saw_rst), 0, "dip of filter length");
      saw_rst = 0; dip(FILT + 1); wait_low(n);
      chk("R4", int'(saw_rst), 1, "dip one past filter");
      chk("R5", n, 2, "recovery without timer");
      chk("R11", int'(rdata), 2, "trip clears bod flag only");
      // R5 / R6: recovery with timer, re-trip during timer
      cur_req = "R5";
      do_por(0, 2'd3); wait_low(n); write_reg(8'h03);
      dip(FILT + 4); wait_low(n); chk("R5", n, PWRT + 2, "recovery with timer");
      cur_req = "R6";
      dip(FILT + 2); repeat (4) step();
      dip(FILT + 2); wait_low(n); chk("R6", n, PWRT + 2, "timer restarts in full");
      // R11: trip beats simultaneous write
      cur_req = "R11";
      write_reg(8'h03);
      step(); bod_low = 1; repeat (FILT + 1) step();
      wr = 1; wdata = 8'h01; step(); wr = 0; bod_low = 0;
      chk("R11", int'(rdata[0]), 0, "trip wins over write");
      wait_low(n);
      // R7: disabled detection ignores comparator
      cur_req = "R7";
      write_reg(8'h03); bod_en = 0; saw_rst = 0;
      dip(FILT + 8); repeat (3) step();
      chk("R7", int'(saw_rst), 0, "disabled detect no reset");
      chk("R7", int'(rdata), 3, "disabled detect keeps flags");
      bod_en = 1;
      // R8: pin held through the time-outs
      cur_req = "R8";
      step(); pin_n = 0;
      do_por(0, 2'd3);
      repeat (PWRT + OST + 6) step();
      chk("R8", int'(rst_int), 1, "pin still holds reset");
      pin_n = 1; wait_low(n); chk("R8", n, 2, "late release ends at once");
      // random phase against the expectation model
      cur_req = "R5";
      for (int i = 0; i < 6000; i++) begin
         step();
         por     = ($urandom_range(0, 799) == 0);
         if ($urandom_range(0, 9) == 0) bod_low = ~bod_low;
         pin_n   = ($urandom_range(0, 39) != 0);
         wr      = ($urandom_range(0, 19) == 0);
         wdata   = 8'($urandom);
         tick    = ($urandom_range(0, 9) < 7);
         if ($urandom_range(0, 199) == 0) bod_en = ~bod_en;
         if ($urandom_range(0, 149) == 0) pwrt_n = ~pwrt_n;
         if ($urandom_range(0, 149) == 0) mode = 2'($urandom);
      end
      step(); wr = 0; por = 0; bod_low = 0; pin_n = 1; tick = 1;
      repeat (4) step();
      mchk = 0;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule